// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small fully associative table that translates the segment part of an effective address into a virtual segment word. Each slot stores two 64-bit halves: a segment-identifier word, which carries the effective segment bits and a valid flag, and a virtual word, whose top two bits select the segment size (256 MB or 1 TB) and whose other bits are attributes that the block keeps but does not interpret.

A combinational lookup port returns hit, slot number and the virtual word of the matching slot in the same cycle. A single command port carries one operation per cycle: write a slot, read a slot back, drop the slot that matches an address, or drop every slot except slot 0. Writes and reads that break the slot or size rules raise a one-cycle error flag and change nothing. The slot count is a parameter, and so is support for 1 TB segments.

Top module: `slb_array`

## Requirements
- R1: After a synchronous active-low reset every slot holds zero in both halves, no lookup hits, and `op_err`, `rd_esid` and `rd_vsid` are zero.
- R2: A lookup hits a slot whose size field (virtual word bits 63:62) is 00 when its stored identifier word equals the lookup address with bits 27:0 cleared and then bit 27 (the valid flag) set.
- R3: A lookup hits a slot whose size field is 01 when its stored identifier word equals the lookup address with bits 39:0 cleared and then bit 27 set.
- R4: On a miss `lk_hit`, `lk_slot` and `lk_vsid` are all zero; when several slots hit, the lowest-numbered one is reported.
- R5: Op code 1 writes slot `op_rb[11:0]`: the identifier half becomes `op_rb` with bits 26:0 cleared, the virtual half becomes `op_rs`. It fails if any of bits 11 to log2(N_ENT) of `op_rb` is set.
- R6: A write fails when the size field of `op_rs` is 10 or 11, and when it is 01 while 1 TB support (EN_1T) is off.
- R7: Op code 2 reads slot `op_rb[11:0]`; one cycle later `rd_esid`/`rd_vsid` hold its two halves. It fails when that slot number is not below N_ENT, and then both outputs read zero.
- R8: Op code 3 clears bit 27 of the identifier word of the lowest slot that `op_rb` hits as a lookup address, and of no other slot; with no hit it does nothing.
- R9: Op code 4 clears bit 27 of the identifier word of every slot except slot 0.
- R10: A failed operation raises `op_err` for exactly the one cycle after it and leaves every slot unchanged; op codes 0, 5, 6 and 7 do nothing, and only op codes 1 and 2 can raise `op_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 3 | Command: 0 none, 1 write, 2 read, 3 drop by address, 4 drop all but slot 0 |
| op_rb | input | 64 | Slot/identifier operand for write and read; address for drop by address |
| op_rs | input | 64 | Virtual word for write |
| op_err | output | 1 | One-cycle pulse after a failed write or read |
| rd_esid | output | 64 | Identifier half from the last read |
| rd_vsid | output | 64 | Virtual half from the last read |
| lk_ea | input | 64 | Lookup address |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_slot | output | log2(N_ENT) | Matching slot number |
| lk_vsid | output | 64 | Virtual word of the matching slot |

## Verification
The bench builds the main instance with eight slots and 1 TB support on, which keeps the random address pool small enough that 256 MB and 1 TB slots collide on the same addresses, several slots hit at once, and slot numbers from 8 to 4095 land in the illegal range of the 12-bit field. A second instance with 1 TB support off makes the rejection of size code 01 reachable. Both instances use a power-of-two slot count so the illegal-index bits are a clean upper range.

// File: rtl/slb_pkg.sv
// Shared constants and types for the segment lookaside array.
// Assumes 64-bit words; field positions here are decoded by neighbours.
package slb_pkg;
    localparam int WORD_W     = 64;
    localparam int SEG256_LSB = 28;   // lowest identifier bit of a 256 MB segment
    localparam int SEG1T_LSB  = 40;   // lowest identifier bit of a 1 TB segment
    localparam int VBIT       = 27;   // valid flag in the identifier word
    localparam int SLOT_W     = 12;   // slot field width in the index operand
    localparam logic [WORD_W-1:0] ESID_KEEP = {{(WORD_W-VBIT){1'b1}}, {VBIT{1'b0}}};

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_WRITE   = 3'd1,
        OP_READ    = 3'd2,
        OP_INV_EA  = 3'd3,
        OP_INV_ALL = 3'd4
    } slb_op_e;

    localparam logic [1:0] SZ_256M = 2'b00;
    localparam logic [1:0] SZ_1T   = 2'b01;

    typedef struct packed {
        logic [WORD_W-1:0] esid;
        logic [WORD_W-1:0] vsid;
    } slb_ent_t;
endpackage

// File: rtl/slb_match.sv
// Compares one address against every slot and returns a hit vector.
// Assumes the size field sits in virtual word bits 63:62.
module slb_match
    import slb_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  slb_ent_t [N_ENT-1:0] ents,
    input  logic [WORD_W-1:0]    ea,
    output logic [N_ENT-1:0]     hit_vec
);
    logic [WORD_W-1:0] key_small;
    logic [WORD_W-1:0] key_large;

    // Build the two segment keys with the valid flag set.
    always_comb begin
        key_small = {ea[WORD_W-1:SEG256_LSB], {SEG256_LSB{1'b0}}} | (WORD_W'(1) << VBIT);
        key_large = {ea[WORD_W-1:SEG1T_LSB], {SEG1T_LSB{1'b0}}} | (WORD_W'(1) << VBIT);
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        // Each slot matches on the key chosen by its own size field.
        assign hit_vec[i] =
            ((ents[i].esid == key_small) && (ents[i].vsid[WORD_W-1:WORD_W-2] == SZ_256M)) ||
            ((ents[i].esid == key_large) && (ents[i].vsid[WORD_W-1:WORD_W-2] == SZ_1T));
    end
endmodule

// File: rtl/slb_prio.sv
// Reduces a hit vector to a hit flag and the lowest set index.
// Assumes N_ENT is at least 2.
module slb_prio #(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] hit_vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so the lowest set bit is the last one written.
    always_comb begin
        hit = |hit_vec;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/slb_array.sv
// Segment lookaside array: storage, command decode, lookup outputs.
// Assumes N_ENT is a power of two between 2 and 2048; one command per cycle.
module slb_array
    import slb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter bit EN_1T = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               op_code,
    input  logic [63:0]              op_rb,
    input  logic [63:0]              op_rs,
    output logic                     op_err,
    output logic [63:0]              rd_esid,
    output logic [63:0]              rd_vsid,
    input  logic [63:0]              lk_ea,
    output logic                     lk_hit,
    output logic [$clog2(N_ENT)-1:0] lk_slot,
    output logic [63:0]              lk_vsid
);
    localparam int IDX_W  = $clog2(N_ENT);
    localparam int N_PORT = 2;   // port 0: lookup, port 1: drop by address

    slb_ent_t [N_ENT-1:0]               ent_q;
    logic [N_PORT-1:0][WORD_W-1:0]      port_ea;
    logic [N_PORT-1:0][N_ENT-1:0]       port_hv;
    logic [N_PORT-1:0]                  port_hit;
    logic [N_PORT-1:0][IDX_W-1:0]       port_idx;

    logic             slot_bad;
    logic [IDX_W-1:0] slot;
    logic [1:0]       sz;
    logic             sz_bad;

    assign port_ea[0] = lk_ea;
    assign port_ea[1] = op_rb;

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        slb_match #(.N_ENT(N_ENT)) u_match (
            .ents    (ent_q),
            .ea      (port_ea[p]),
            .hit_vec (port_hv[p])
        );
        slb_prio #(.N_ENT(N_ENT)) u_prio (
            .hit_vec (port_hv[p]),
            .hit     (port_hit[p]),
            .idx     (port_idx[p])
        );
    end

    // Decode slot and size legality from the operands.
    always_comb begin
        slot     = op_rb[IDX_W-1:0];
        slot_bad = |op_rb[SLOT_W-1:IDX_W];
        sz       = op_rs[WORD_W-1:WORD_W-2];
        sz_bad   = sz[1] || ((sz == SZ_1T) && !EN_1T);
    end

    // Drive lookup results, zero on a miss.
    always_comb begin
        lk_hit  = port_hit[0];
        lk_slot = port_hit[0] ? port_idx[0] : '0;
        lk_vsid = port_hit[0] ? ent_q[port_idx[0]].vsid : '0;
    end

    // Execute one command per cycle against the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q   <= '0;
            op_err  <= 1'b0;
            rd_esid <= '0;
            rd_vsid <= '0;
        end else begin
            op_err <= 1'b0;
            case (op_code)
                OP_WRITE: begin
                    if (slot_bad || sz_bad) begin
                        op_err <= 1'b1;
                    end else begin
                        ent_q[slot].esid <= op_rb & ESID_KEEP;
                        ent_q[slot].vsid <= op_rs;
                    end
                end
                OP_READ: begin
                    if (slot_bad) begin
                        op_err  <= 1'b1;
                        rd_esid <= '0;
                        rd_vsid <= '0;
                    end else begin
                        rd_esid <= ent_q[slot].esid;
                        rd_vsid <= ent_q[slot].vsid;
                    end
                end
                OP_INV_EA: begin
                    if (port_hit[1]) ent_q[port_idx[1]].esid[VBIT] <= 1'b0;
                end
                OP_INV_ALL: begin
                    for (int i = 1; i < N_ENT; i++) ent_q[i].esid[VBIT] <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/slb_array_chk.sv
// Checker for the segment lookaside array, attached by bind.
// Assumes the op code values listed in the package.
module slb_array_chk #(
    parameter int N_ENT = 8,
    parameter bit EN_1T = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2:0]               op_code,
    input logic                     op_err,
    input logic [63:0]              rd_esid,
    input logic [63:0]              rd_vsid,
    input logic                     lk_hit,
    input logic [$clog2(N_ENT)-1:0] lk_slot,
    input logic [63:0]              lk_vsid
);
    // R10: only write and read commands can raise the error flag
    a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> ($past(op_code) == 3'd1 || $past(op_code) == 3'd2));

    // R4: a miss drives zero slot and zero word
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_slot == '0 && lk_vsid == 64'd0));

    // R9: right after drop-all only slot 0 can hit
    a_r9_keep_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd4) |=> (!lk_hit || lk_slot == '0));

    // R6: a hitting slot never carries an illegal size code
    a_r6_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_vsid[63] == 1'b0 && (EN_1T || lk_vsid[62] == 1'b0)));

    // R7: a failed read returns zero halves
    a_r7_read_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_err && $past(op_code) == 3'd2) |-> (rd_esid == 64'd0 && rd_vsid == 64'd0));
endmodule

bind slb_array slb_array_chk #(.N_ENT(N_ENT), .EN_1T(EN_1T)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_code (op_code),
    .op_err  (op_err),
    .rd_esid (rd_esid),
    .rd_vsid (rd_vsid),
    .lk_hit  (lk_hit),
    .lk_slot (lk_slot),
    .lk_vsid (lk_vsid)
);

// File: tb/slb_array_bench.sv
`timescale 1ns/1ps
module slb_array_bench;
    localparam int N = 8;
    localparam logic [63:0] KEEP = 64'hFFFF_FFFF_F800_0000;
    localparam logic [63:0] VFLG = 64'h0000_0000_0800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = '0;
    logic [63:0] op_rb = '0, op_rs = '0, lk_ea = '0;
    logic        op_err, lk_hit;
    logic [63:0] rd_esid, rd_vsid, lk_vsid;
    logic [2:0]  lk_slot;

    logic [2:0]  b_code = '0;
    logic [63:0] b_rb = '0, b_rs = '0, b_ea = '0;
    logic        b_err, b_hit;
    logic [63:0] b_resid, b_rvsid, b_lvsid;
    logic [2:0]  b_slot;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] m_esid [N];
    logic [63:0] m_vsid [N];

    always #4 clk = ~clk;

    slb_array #(.N_ENT(N), .EN_1T(1'b1)) u_slb_array (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_rb(op_rb), .op_rs(op_rs),
        .op_err(op_err), .rd_esid(rd_esid), .rd_vsid(rd_vsid),
        .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_vsid(lk_vsid));

    slb_array #(.N_ENT(N), .EN_1T(1'b0)) u_slb_array_no1t (
        .clk(clk), .rst_n(rst_n), .op_code(b_code), .op_rb(b_rb), .op_rs(b_rs),
        .op_err(b_err), .rd_esid(b_resid), .rd_vsid(b_rvsid),
        .lk_ea(b_ea), .lk_hit(b_hit), .lk_slot(b_slot), .lk_vsid(b_lvsid));

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void m_lookup(input logic [63:0] ea, output bit hit, output int slot);
        logic [63:0] k_s, k_l;
        k_s = {ea[63:28], 28'd0} | VFLG;
        k_l = {ea[63:40], 40'd0} | VFLG;
        hit = 0;
        slot = 0;
        for (int i = 0; i < N; i++) begin
            if (!hit && ((m_esid[i] == k_s && m_vsid[i][63:62] == 2'b00) ||
                         (m_esid[i] == k_l && m_vsid[i][63:62] == 2'b01))) begin
                hit = 1;
                slot = i;
            end
        end
    endfunction

    function automatic logic [63:0] rand_ea();
        return {24'hA00000 + 24'($urandom % 3), 12'($urandom % 3), 28'($urandom)};
    endfunction

    function automatic logic [63:0] rand_wr_rb();
        logic [63:0] ea;
        logic [11:0] s;
        ea = rand_ea();
        s = ($urandom % 16 == 0) ? 12'(8 + $urandom % 4088) : 12'($urandom % 8);
        return {ea[63:28], 1'($urandom % 8 != 0), 15'($urandom), s};
    endfunction

    function automatic logic [63:0] rand_rs();
        int r;
        logic [1:0] sz;
        r = $urandom % 10;
        sz = (r < 6) ? 2'b00 : (r < 9) ? 2'b01 : 2'(2 + $urandom % 2);
        return {sz, 30'($urandom), 32'($urandom)};
    endfunction

    // Lookup check: R2/R3/R4 against the model
    task automatic lk_check(input logic [63:0] ea, input string req);
        bit h;
        int s;
        lk_ea = ea;
        #1;
        m_lookup(ea, h, s);
        chk({63'd0, lk_hit}, {63'd0, h}, req);
        chk({61'd0, lk_slot}, h ? 64'(s) : 64'd0, req);
        chk(lk_vsid, h ? m_vsid[s] : 64'd0, req);
    endtask

    task automatic run_op(input logic [2:0] c, input logic [63:0] rb, input logic [63:0] rs);
        bit exp_err, h;
        int s;
        logic [11:0] sl;
        sl = rb[11:0];
        exp_err = 0;
        if (c == 3'd1) exp_err = (sl >= N) || rs[63];
        if (c == 3'd2) exp_err = (sl >= N);
        @(negedge clk);
        op_code = c; op_rb = rb; op_rs = rs;
        @(negedge clk);
        op_code = 3'd0;
        chk({63'd0, op_err}, {63'd0, exp_err}, "R10 error flag (R5/R6/R7)");
        if (c == 3'd2) begin
            chk(rd_esid, exp_err ? 64'd0 : m_esid[sl[2:0]], "R7 read identifier");
            chk(rd_vsid, exp_err ? 64'd0 : m_vsid[sl[2:0]], "R7 read virtual");
        end
        case (c)
            3'd1: if (!exp_err) begin
                m_esid[sl[2:0]] = rb & KEEP;
                m_vsid[sl[2:0]] = rs;
            end
            3'd3: begin
                m_lookup(rb, h, s);
                if (h) m_esid[s][27] = 1'b0;
            end
            3'd4: for (int i = 1; i < N; i++) m_esid[i][27] = 1'b0;
            default: ;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] base;
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) begin m_esid[i] = '0; m_vsid[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk({63'd0, op_err}, 64'd0, "R1 reset error flag");
        chk(rd_esid, 64'd0, "R1 reset read");
        lk_check(64'd0, "R1 reset lookup miss");
        for (int i = 0; i < N; i++) run_op(3'd2, 64'(i), 64'd0);

        // R2/R5: 256 MB slot with junk in the masked bits
        base = 64'hA00000_001_0000000;
        run_op(3'd1, base | VFLG | 64'h0000_0000_0012_3003, 64'h0123_4567_89AB_CDEF);
        run_op(3'd2, 64'd3, 64'd0);
        chk(rd_esid, base | VFLG, "R5 stored identifier masked");
        lk_check(base | 64'h0ABC_DEF, "R2 256MB hit");
        lk_check(64'hA00000_002_0000000, "R2 other segment miss");

        // R4: duplicate in slot 5, lowest wins
        run_op(3'd1, base | VFLG | 64'd5, 64'h0000_0000_0000_5555);
        lk_check(base | 64'h55, "R4 lowest slot wins");

        // R3: 1 TB slot in slot 1
        run_op(3'd1, 64'hA00001_000_0000000 | VFLG | 64'd1, 64'h4000_0000_0000_1111);
        lk_check(64'hA00001_FFF_1234567, "R3 1TB hit any mid bits");
        lk_check(64'hA00001_000_0000000, "R3 1TB hit");

        // R5/R6/R10: failures leave array unchanged, pulse lasts one cycle
        run_op(3'd1, base | VFLG | 64'd8, 64'd0);
        run_op(3'd1, base | VFLG | 64'h800, 64'd0);
        run_op(3'd1, VFLG | 64'd2, 64'h8000_0000_0000_0000);
        run_op(3'd1, VFLG | 64'd3, 64'hC000_0000_0000_0000);
        @(negedge clk);
        chk({63'd0, op_err}, 64'd0, "R10 error pulse one cycle");
        run_op(3'd2, 64'd3, 64'd0);
        run_op(3'd2, 64'd9, 64'd0);
        run_op(3'd2, 64'hFFFF_FFFF_FFFF_F001, 64'd0);
        run_op(3'd6, base | VFLG | 64'd2, 64'd7);
        lk_check(base, "R10 unused op no effect");

        // R8: drop by address clears only the lowest hit
        run_op(3'd3, base | 64'h777, 64'd0);
        lk_check(base, "R8 next slot now hits");
        run_op(3'd2, 64'd3, 64'd0);
        chk(rd_esid, base, "R8 valid cleared in slot 3");
        run_op(3'd3, 64'hB00000_000_0000000, 64'd0);
        lk_check(base, "R8 miss drops nothing");

        // R9: drop-all spares slot 0
        run_op(3'd1, base | VFLG | 64'd0, 64'h0000_0000_0000_0AAA);
        run_op(3'd4, 64'd0, 64'd0);
        lk_check(base, "R9 slot 0 survives");
        lk_check(64'hA00001_000_0000000, "R9 1TB slot dropped");

        // R6: 1 TB rejected when disabled
        @(negedge clk);
        b_code = 3'd1; b_rb = 64'hA00001_000_0000000 | VFLG | 64'd2; b_rs = 64'h4000_0000_0000_0001;
        @(negedge clk);
        b_code = 3'd0; b_ea = 64'hA00001_000_0000000;
        chk({63'd0, b_err}, 64'd1, "R6 1TB rejected when disabled");
        #1 chk({63'd0, b_hit}, 64'd0, "R6 rejected slot absent");
        @(negedge clk);
        b_code = 3'd1; b_rs = 64'h0000_0000_0000_0002;
        @(negedge clk);
        b_code = 3'd0; b_ea = 64'hA00001_000_0000000;
        chk({63'd0, b_err}, 64'd0, "R6 256MB accepted when 1TB disabled");
        #1 chk({61'd0, b_slot}, 64'd2, "R6 256MB slot hits");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int r;
            r = $urandom % 16;
            if (r < 7)       run_op(3'd1, rand_wr_rb(), rand_rs());
            else if (r < 10) run_op(3'd2, {52'($urandom), ($urandom % 8 == 0) ? 12'($urandom) : 12'($urandom % 8)}, 64'd0);
            else if (r < 13) run_op(3'd3, rand_ea(), 64'd0);
            else if (r < 14) run_op(3'd4, 64'd0, 64'd0);
            else             run_op(3'(5 + $urandom % 3), rand_wr_rb(), rand_rs());
            lk_check(rand_ea(), "R2/R3/R4 random lookup");
            lk_check(rand_ea(), "R2/R3/R4 random lookup");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule